// File: doc/BRIEF.md
# Row Address Sequencer with Fast Cueing

This block walks a row pointer through a message store of a fixed number of rows, producing the row-boundary clock that external logic uses to manage messages. A command port starts playback, recording or a fast cue scan from a given row, or halts the current operation. Time is measured in sample ticks. Each tick is made from the incoming clock, first halved and then counted down by a parameter. A row is split into eight equal segments, each able to hold one end-of-message marker. The marker pattern for the current row arrives on an 8-bit input.

During playback the sequencer stops at the first marker it meets and raises a one-cycle end-of-message pulse. A cue scan uses a shorter row and stops on a marker in the same way, then leaves the pointer on the row after it so that the next message is ready. Recording ignores markers. It also holds the row clock released for one extra segment before normal row timing begins. Running off the end of the last row raises a one-cycle overflow pulse. After either pulse the sequencer goes idle. The row clock output is a pull-low request for an open-drain pad, so the line is either pulled low or left floating.

Top module: `row_seq`

## Requirements
- R1: After reset, busy, eom_pulse, ovf_pulse and row_clk_pull_low are 0 and row_addr is 0.
- R2: A command with cmd_valid high and cmd_op = 01 (play), 10 (record) or 11 (cue) loads row_addr from cmd_addr and sets busy at that clock edge. If cmd_addr is not below ROWS, the command is dropped and busy and row_addr keep their values.
- R3: After a start, the k-th sample tick is taken 2*CLKS_PER_TICK*k clocks after the start edge. A row lasts ROW_TICKS ticks (play, record) or CUE_ROW_TICKS ticks (cue), split into eight equal segments. row_addr steps by one at each row end that produces no pulse.
- R4: While busy, row_clk_pull_low is 1 exactly during the last (eighth) segment of each row. It is 0 at every other time, including whenever the block is idle.
- R5: A record start inserts one extra segment of ticks, with the row clock released, before the first segment of the first row.
- R6: In play, marker_bits bit k stands for the end of segment k (bit 0 is the first segment). If that bit is set when segment k of the current row ends, eom_pulse is raised for one cycle, busy drops and row_addr stays on that row.
- R7: In cue, a marker stops the scan as in R6, but row_addr moves to the following row, wrapping to 0 after row ROWS-1.
- R8: In record, marker_bits has no effect. The operation runs until overflow.
- R9: When the last segment of row ROWS-1 ends without a marker, ovf_pulse is raised for one cycle, busy drops and row_addr stays at ROWS-1. If a marker sits in that same segment (play or cue), only eom_pulse is raised.
- R10: cmd_valid with cmd_op = 00 (halt) clears busy at that edge, produces no pulse and leaves row_addr unchanged.
- R11: eom_pulse and ovf_pulse are never high in the same cycle, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock; halved internally |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 00 halt, 01 play, 10 record, 11 cue |
| cmd_addr | input | ADDR_W | Starting row |
| marker_bits | input | 8 | End-of-message markers of the current row, one per segment |
| row_addr | output | ADDR_W | Current row pointer |
| busy | output | 1 | An operation is running |
| eom_pulse | output | 1 | One-cycle end-of-message event |
| ovf_pulse | output | 1 | One-cycle end-of-memory event |
| row_clk_pull_low | output | 1 | Pull request for the open-drain row clock pad |

## Verification
End-of-message detection and end-of-memory detection can both fall on the same edge: the closing segment of the final row, carrying a marker. Directed runs place a marker in bit 7 of the final row, in play and in cue. The bench then expects a single end-of-message pulse with no overflow: the row held in play, and the pointer wrapped to row 0 in cue. Random runs near the top of memory mix sparse markers with unmarked stretches, so both outcomes occur and are compared against a per-segment model of the event cycle.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
   typedef enum logic [1:0] {
      OP_HALT = 2'b00,
      OP_PLAY = 2'b01,
      OP_REC  = 2'b10,
      OP_CUE  = 2'b11
   } rowseq_op_e;
endpackage

// File: rtl/rowseq_tick_gen.sv
module rowseq_tick_gen #(
   parameter int CLKS_PER_TICK = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic tick
);
   logic half;

   // divide the incoming clock by two; only the enable phase is used
   always_ff @(posedge clk) begin
      if (!rst_n || clear) half <= 1'b0;
      else                 half <= ~half;
   end

   generate
      if (CLKS_PER_TICK < 1) begin : g_bad
         $error("CLKS_PER_TICK must be at least 1");
      end
      if (CLKS_PER_TICK == 1) begin : g_direct
         assign tick = half;
      end else begin : g_count
         localparam int CW = $clog2(CLKS_PER_TICK);
         localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || clear)  cnt <= '0;
            else if (half)        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
         assign tick = half && (cnt == LAST);
         a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= LAST);
      end
   endgenerate
endmodule

// File: rtl/rowseq_seg_timer.sv
module rowseq_seg_timer #(
   parameter int ROW_TICKS     = 1600,
   parameter int CUE_ROW_TICKS = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       run,
   input  logic       cue,
   input  logic       prelude,
   input  logic       tick,
   output logic       seg_done,
   output logic [2:0] seg_idx,
   output logic       pull_low
);
   localparam int NORM_SEG = ROW_TICKS / 8;
   localparam int CUE_SEG  = CUE_ROW_TICKS / 8;
   localparam int MAX_SEG  = (NORM_SEG > CUE_SEG) ? NORM_SEG : CUE_SEG;
   localparam int SEG_W    = (MAX_SEG > 1) ? $clog2(MAX_SEG) : 1;
   localparam logic [SEG_W-1:0] NORM_M1 = SEG_W'(NORM_SEG - 1);
   localparam logic [SEG_W-1:0] CUE_M1  = SEG_W'(CUE_SEG - 1);

   generate
      if (ROW_TICKS % 8 != 0 || ROW_TICKS < 8) begin : g_bad_row
         $error("ROW_TICKS must be a positive multiple of 8");
      end
      if (CUE_ROW_TICKS % 8 != 0 || CUE_ROW_TICKS < 8) begin : g_bad_cue
         $error("CUE_ROW_TICKS must be a positive multiple of 8");
      end
   endgenerate

   logic [SEG_W-1:0] seg_cnt;
   logic [SEG_W-1:0] len_m1;
   logic             in_pre;
   logic             boundary;

   assign len_m1   = cue ? CUE_M1 : NORM_M1;
   assign boundary = run && tick && (seg_cnt == len_m1);
   assign seg_done = boundary && !in_pre;
   assign pull_low = run && !in_pre && (seg_idx == 3'd7);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_cnt <= '0;
         seg_idx <= '0;
         in_pre  <= 1'b0;
      end else if (clear) begin
         seg_cnt <= '0;
         seg_idx <= '0;
         in_pre  <= prelude;
      end else if (run && tick) begin
         if (boundary) begin
            seg_cnt <= '0;
            if (in_pre) in_pre  <= 1'b0;
            else        seg_idx <= seg_idx + 3'd1;
         end else begin
            seg_cnt <= seg_cnt + 1'b1;
         end
      end
   end

   a_r4_seg_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> seg_cnt <= len_m1);
   a_r5_pre_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      in_pre |-> !pull_low && !seg_done);
endmodule

// File: rtl/row_seq.sv
module row_seq
   import rowseq_pkg::*;
#(
   parameter int ROWS          = 2400,
   parameter int ROW_TICKS     = 1600,
   parameter int CUE_ROW_TICKS = 1000,
   parameter int CLKS_PER_TICK = 1,
   localparam int ADDR_W       = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        marker_bits,
   output logic [ADDR_W-1:0] row_addr,
   output logic              busy,
   output logic              eom_pulse,
   output logic              ovf_pulse,
   output logic              row_clk_pull_low
);
   localparam logic [ADDR_W-1:0] LAST_ROW = ADDR_W'(ROWS - 1);

   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("ROWS must be at least 2");
      end
   endgenerate

   rowseq_op_e op_in, mode;
   logic       addr_ok, accept, start, tick, seg_done, pull_low;
   logic       marker_hit, row_end;
   logic [2:0] seg_idx;

   assign op_in   = rowseq_op_e'(cmd_op);
   assign addr_ok = {1'b0, cmd_addr} < (ADDR_W + 1)'(ROWS);
   assign accept  = cmd_valid && (op_in == OP_HALT || addr_ok);
   assign start   = accept && (op_in != OP_HALT);

   rowseq_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start),
      .tick  (tick)
   );

   rowseq_seg_timer #(.ROW_TICKS(ROW_TICKS), .CUE_ROW_TICKS(CUE_ROW_TICKS)) u_seg (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start),
      .run      (busy),
      .cue      (mode == OP_CUE),
      .prelude  (op_in == OP_REC),
      .tick     (tick),
      .seg_done (seg_done),
      .seg_idx  (seg_idx),
      .pull_low (pull_low)
   );

   assign marker_hit       = (mode != OP_REC) && marker_bits[seg_idx];
   assign row_end          = seg_idx == 3'd7;
   assign row_clk_pull_low = pull_low;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         mode      <= OP_HALT;
         row_addr  <= '0;
         eom_pulse <= 1'b0;
         ovf_pulse <= 1'b0;
      end else begin
         eom_pulse <= 1'b0;
         ovf_pulse <= 1'b0;
         if (start) begin
            busy     <= 1'b1;
            mode     <= op_in;
            row_addr <= cmd_addr;
         end else if (accept) begin
            busy <= 1'b0;
         end else if (busy && seg_done) begin
            if (marker_hit) begin
               // marker outranks end of memory on the same segment
               eom_pulse <= 1'b1;
               busy      <= 1'b0;
               if (mode == OP_CUE)
                  row_addr <= (row_addr == LAST_ROW) ? '0 : row_addr + 1'b1;
            end else if (row_end) begin
               if (row_addr == LAST_ROW) begin
                  ovf_pulse <= 1'b1;
                  busy      <= 1'b0;
               end else begin
                  row_addr <= row_addr + 1'b1;
               end
            end
         end
      end
   end

   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(eom_pulse && ovf_pulse));
   a_r11_eom_single: assert property (@(posedge clk) disable iff (!rst_n)
      eom_pulse |=> !eom_pulse);
   a_r11_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |=> !ovf_pulse);
   a_r4_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !row_clk_pull_low);
   a_r9_ovf_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> (row_addr == LAST_ROW) && !busy);
   a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, row_addr} < (ADDR_W + 1)'(ROWS));
   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) && !$past(cmd_valid) |->
         (row_addr == $past(row_addr)) || (row_addr == $past(row_addr) + 1'b1));
   a_r10_halt: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && op_in == OP_HALT |=> !busy && !eom_pulse && !ovf_pulse);
endmodule

// File: tb/row_seq_bench.sv
module row_seq_bench;
   localparam int ROWS = 2400;
   localparam int RT   = 16;
   localparam int CRT  = 8;
   localparam int AW   = $clog2(ROWS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'b00;
   logic [AW-1:0] cmd_addr = '0;
   logic [7:0]    marker_bits;
   logic [AW-1:0] row_addr;
   logic          busy, eom_pulse, ovf_pulse, row_clk_pull_low;

   int tests = 0, fails = 0;
   int seed = 0, frow = -1, use_rand = 0;
   logic [7:0] fbits = '0;

   always #2 clk = ~clk;

   function automatic logic [7:0] mk(input int r);
      if (r == frow) return fbits;
      if (use_rand != 0 && ((r * 7 + seed) % 13) == 0) return 8'(1 << ((r + seed) % 8));
      return 8'h00;
   endfunction

   assign marker_bits = mk(int'(row_addr));

   row_seq #(.ROWS(ROWS), .ROW_TICKS(RT), .CUE_ROW_TICKS(CRT), .CLKS_PER_TICK(1)) u_row_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .marker_bits(marker_bits), .row_addr(row_addr),
      .busy(busy), .eom_pulse(eom_pulse), .ovf_pulse(ovf_pulse),
      .row_clk_pull_low(row_clk_pull_low)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // kind: 1 end-of-message, 2 overflow
   task automatic predict(input int op, input int st, output int kind, output int ticks,
                          output int faddr);
      int s, p, n;
      s = (op == 3) ? CRT / 8 : RT / 8;
      p = (op == 2) ? s : 0;
      n = 0;
      for (int r = st; r < ROWS; r++) begin
         for (int k = 0; k < 8; k++) begin
            n++;
            if (op != 2 && mk(r)[k]) begin
               kind  = 1;
               ticks = p + n * s;
               faddr = (op == 3) ? ((r == ROWS - 1) ? 0 : r + 1) : r;
               return;
            end
         end
      end
      kind = 2; ticks = p + n * s; faddr = ROWS - 1;
   endtask

   task automatic issue(input int op, input int addr);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_addr = AW'(addr);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic run_case(input int op, input int st, input string tag);
      int kind, ticks, faddr, c, mism, got, s, p, e;
      bit exp_pull;
      predict(op, st, kind, ticks, faddr);
      s = (op == 3) ? CRT / 8 : RT / 8;
      p = (op == 2) ? s : 0;
      issue(op, st);
      check(busy && row_addr == AW'(st), "R2 start load", int'(row_addr), st);
      c = 0; mism = 0; got = 0;
      while (got == 0 && c < 4000) begin
         @(posedge clk); c++;
         @(negedge clk);
         if (eom_pulse && ovf_pulse) got = 3;
         else if (eom_pulse) got = 1;
         else if (ovf_pulse) got = 2;
         else begin
            e = c / 2 - p;
            exp_pull = (e >= 0) && (((e / s) % 8) == 7);
            if (row_clk_pull_low !== exp_pull || !busy) mism++;
         end
      end
      check(mism == 0, {tag, " R4 R5 row clock shape"}, mism, 0);
      check(got == kind, {tag, " R6 R7 R8 R9 event kind"}, got, kind);
      check(c == 2 * ticks, {tag, " R3 event cycle"}, c, 2 * ticks);
      check(int'(row_addr) == faddr && !busy, {tag, " R6 R7 R9 final row"}, int'(row_addr), faddr);
      @(negedge clk);
      check(!eom_pulse && !ovf_pulse && !row_clk_pull_low, {tag, " R11 single pulse"},
            int'(eom_pulse) + int'(ovf_pulse), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int held, quiet;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!busy && !eom_pulse && !ovf_pulse && !row_clk_pull_low && row_addr == '0,
            "R1 reset state", int'(busy), 0);
      rst_n = 1'b1;

      // R6: marker on first segment of the start row
      use_rand = 0; frow = 2390; fbits = 8'h01;
      run_case(1, 2390, "R6 play first segment");
      // R9 with R6 coincidence: marker in last segment of last row
      frow = ROWS - 1; fbits = 8'h80;
      run_case(1, ROWS - 1, "R9 play eom beats overflow");
      // R7: cue wraps to row 0
      run_case(3, ROWS - 2, "R7 cue wrap");
      // R7: cue stop mid-memory
      frow = 2385; fbits = 8'h10;
      run_case(3, 2381, "R7 cue next row");
      // R8 R5: record ignores a full marker row
      frow = ROWS - 2; fbits = 8'hFF;
      run_case(2, ROWS - 3, "R8 record ignores markers");
      // R9: play with no markers reaches overflow
      frow = -1;
      run_case(1, ROWS - 2, "R9 play overflow");

      // R2: out-of-range start is dropped
      held = int'(row_addr);
      issue(1, ROWS);
      check(!busy && int'(row_addr) == held, "R2 reject address", int'(row_addr), held);

      // R10: halt mid-run
      frow = -1; use_rand = 0;
      issue(1, 2390);
      repeat (3) @(negedge clk);
      issue(0, 0);
      check(!busy && row_addr == AW'(2390), "R10 halt holds row", int'(row_addr), 2390);
      quiet = 0;
      repeat (200) begin
         @(negedge clk);
         if (eom_pulse || ovf_pulse || row_clk_pull_low || busy) quiet++;
      end
      check(quiet == 0, "R10 silent after halt", quiet, 0);

      // random mix
      use_rand = 1;
      for (int i = 0; i < 30; i++) begin
         int op;
         op = 1 + int'($urandom % 3);
         seed = int'($urandom % 1000);
         frow = -1;
         run_case(op, ROWS - 20 + int'($urandom % 20), "random");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule